// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers six interrupt sources: two active-low external pins, three timer events and one serial event. Each source sets a pending flag. A master enable and a per-source enable gate the flags, and one priority bit per source places it at the high or the low level. The controller picks one winner and presents it to the CPU as a request with a fixed vector address. It keeps that request and vector until the CPU acknowledges it.

Two in-service bits, one per level, record nesting. An acknowledge marks the granted level as busy. A return strobe releases the innermost busy level. As a result, a high-level source can interrupt a low-level handler, and every other request waits. Software reaches the enable, priority, flag and trigger-mode registers through a byte-wide write port and a combinational read port.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, all four registers read zero and `irq_req` is low.
- R2: Register `reg_addr` 0 holds the enables. Bit 7 is the master enable, bit 6 reads as zero, and bits 5..0 enable the sources. The bit index of each source is: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2. Address 1 holds the priority bits at the same positions, and bits 7..6 read as zero. Address 2 holds the pending flags at the same positions. Address 3 holds the trigger modes: bit 0 for external 0 and bit 1 for external 1, where 1 means falling-edge mode and 0 means level mode.
- R3: While the master enable is 0, no new request is raised.
- R4: A pending source whose own enable bit is 0 never wins.
- R5: Within one level, the lowest bit index wins. The vector is 03h plus 8 times the bit index (03h, 0Bh, 13h, 1Bh, 23h, 2Bh).
- R6: Any enabled high-level source beats every low-level source, whatever their bit indices.
- R7: When the high level is in service, no request is raised. When only the low level is in service, only high-level sources raise a request.
- R8: A return strobe clears the high in-service bit if it is set. Otherwise it clears the low one.
- R9: Once raised, `irq_req` and `irq_vec` stay unchanged until `irq_ack`, even if flags or enables change.
- R10: In edge mode, a 1-to-0 change between two consecutive samples of the external pin sets its flag. The acknowledge of that source clears the flag.
- R11: In level mode, the external flag follows the inverted pin level, and an acknowledge does not clear it.
- R12: Acknowledging timer 0 or timer 1 clears that flag. Acknowledging the serial or timer 2 source leaves its flag set.
- R13: A software write to the flag register in the same cycle as a hardware clear takes effect, and the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_n | input | 1 | External request pin 0, active low |
| ext1_n | input | 1 | External request pin 1, active low |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_evt | input | 1 | Timer 2 event pulse |
| ser_evt | input | 1 | Serial event pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the pending request |
| irq_ack | input | 1 | CPU acknowledge of the pending request |
| irq_ret | input | 1 | Return-from-handler strobe |

## Verification
If an in-service bit is stuck or cleared in the wrong order, it shows up one cycle after the next return. A request either appears that should stay blocked, or it stays missing while a source is pending. A wrong hardware clear becomes visible on the flag readback right after the acknowledge edge. It also shows up as a repeated or a lost request one cycle after the return. Errors in the arbitration order or the vector encoding appear on `irq_vec` on the cycle after the winning flag settles.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
    localparam int NSRC = 6;
    localparam int IW   = $clog2(NSRC);
    localparam int NEXT = 2;

    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;

    typedef enum logic [1:0] {
        RA_ENABLE = 2'd0,
        RA_PRIO   = 2'd1,
        RA_FLAG   = 2'd2,
        RA_MODE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic            gen;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] pri;
        logic [NSRC-1:0] flag;
        logic [NEXT-1:0] trig_edge;
        logic            busy_hi;
        logic            busy_lo;
        logic            req;
        logic            lvl;
        logic [IW-1:0]   idx;
    } ctl_state_t;
endpackage

// File: rtl/irqv_pin_sync.sv
`timescale 1ns/1ps
module irqv_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active,
    output logic fall
);
    typedef struct packed {
        logic s1;
        logic s2;
    } pin_state_t;

    pin_state_t p_d, p_q;

    always_comb begin
        p_d    = p_q;
        p_d.s1 = pin_n;
        p_d.s2 = p_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '{s1: 1'b1, s2: 1'b1};
        else        p_q <= p_d;
    end

    assign active = ~p_q.s1;
    assign fall   = p_q.s2 & ~p_q.s1;
endmodule

// File: rtl/irqv_pick.sv
`timescale 1ns/1ps
module irqv_pick #(
    parameter int N  = 6,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  pri,
    output logic          any,
    output logic          lvl,
    output logic [IW-1:0] idx
);
    logic [N-1:0] hi_set;
    logic [N-1:0] use_set;

    always_comb begin
        hi_set  = pend & pri;
        lvl     = |hi_set;
        use_set = lvl ? hi_set : pend;
        any     = |pend;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (use_set[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irqv_ctrl.sv
`timescale 1ns/1ps
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext0_n,
    input  logic       ext1_n,
    input  logic       tmr0_ovf,
    input  logic       tmr1_ovf,
    input  logic       tmr2_evt,
    input  logic       ser_evt,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_req,
    output logic [7:0] irq_vec,
    input  logic       irq_ack,
    input  logic       irq_ret
);
    localparam int FLAG_PAD = 8 - NSRC;

    ctl_state_t st_d, st_q;

    logic [NEXT-1:0] pin_n, pin_act, pin_fall;
    logic [NSRC-1:0] pend;
    logic            win_any, win_lvl, cand_ok, grant;
    logic [IW-1:0]   win_idx;
    logic            spare_unused;

    assign pin_n        = {ext1_n, ext0_n};
    assign spare_unused = ^reg_wdata;

    generate
        for (genvar e = 0; e < NEXT; e++) begin : g_ext
            irqv_pin_sync u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .pin_n (pin_n[e]),
                .active(pin_act[e]),
                .fall  (pin_fall[e])
            );
        end
    endgenerate

    assign pend = st_q.flag & st_q.en & {NSRC{st_q.gen}};

    irqv_pick #(.N(NSRC), .IW(IW)) u_pick (
        .pend(pend),
        .pri (st_q.pri),
        .any (win_any),
        .lvl (win_lvl),
        .idx (win_idx)
    );

    assign cand_ok = win_any && !st_q.busy_hi && (win_lvl || !st_q.busy_lo);
    assign grant   = st_q.req && irq_ack;

    always_comb begin
        st_d = st_q;

        // hardware clear on grant comes before hardware set
        if (grant) begin
            st_d.req = 1'b0;
            if (st_q.lvl) st_d.busy_hi = 1'b1;
            else          st_d.busy_lo = 1'b1;
            case (int'(st_q.idx))
                SRC_EXT0: if (st_q.trig_edge[0]) st_d.flag[SRC_EXT0] = 1'b0;
                SRC_EXT1: if (st_q.trig_edge[1]) st_d.flag[SRC_EXT1] = 1'b0;
                SRC_TMR0: st_d.flag[SRC_TMR0] = 1'b0;
                SRC_TMR1: st_d.flag[SRC_TMR1] = 1'b0;
                default:  ;
            endcase
        end else if (!st_q.req && cand_ok) begin
            st_d.req = 1'b1;
            st_d.lvl = win_lvl;
            st_d.idx = win_idx;
        end

        if (irq_ret) begin
            if (st_q.busy_hi) st_d.busy_hi = 1'b0;
            else              st_d.busy_lo = 1'b0;
            if (grant && st_q.lvl)       st_d.busy_hi = 1'b1;
            else if (grant && !st_q.lvl) st_d.busy_lo = 1'b1;
        end

        for (int e = 0; e < NEXT; e++) begin
            if (st_q.trig_edge[e]) begin
                if (pin_fall[e]) st_d.flag[2*e] = 1'b1;
            end else begin
                st_d.flag[2*e] = pin_act[e];
            end
        end
        if (tmr0_ovf) st_d.flag[SRC_TMR0] = 1'b1;
        if (tmr1_ovf) st_d.flag[SRC_TMR1] = 1'b1;
        if (ser_evt)  st_d.flag[SRC_SER]  = 1'b1;
        if (tmr2_evt) st_d.flag[SRC_TMR2] = 1'b1;

        // software write wins over hardware in the same cycle
        if (reg_we) begin
            case (reg_addr_e'(reg_addr))
                RA_ENABLE: begin
                    st_d.gen = reg_wdata[7];
                    st_d.en  = reg_wdata[NSRC-1:0];
                end
                RA_PRIO: st_d.pri       = reg_wdata[NSRC-1:0];
                RA_FLAG: st_d.flag      = reg_wdata[NSRC-1:0];
                RA_MODE: st_d.trig_edge = reg_wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_ENABLE: reg_rdata = {st_q.gen, {(FLAG_PAD-1){1'b0}}, st_q.en};
            RA_PRIO:   reg_rdata = {{FLAG_PAD{1'b0}}, st_q.pri};
            RA_FLAG:   reg_rdata = {{FLAG_PAD{1'b0}}, st_q.flag};
            default:   reg_rdata = {{(8-NEXT){1'b0}}, st_q.trig_edge};
        endcase
    end

    assign irq_req = st_q.req;
    assign irq_vec = 8'(VEC_BASE + VEC_STEP * int'(st_q.idx));
endmodule

// File: rtl/irqv_chk.sv
`timescale 1ns/1ps
module irqv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_req,
    input logic [7:0] irq_vec,
    input logic       irq_ack,
    input logic       irq_ret,
    input logic       gen,
    input logic       req_lvl,
    input logic       busy_hi,
    input logic       busy_lo
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !irq_ack |=> irq_req && $stable(irq_vec)); // R9

    AST_HI_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_hi |-> !irq_req); // R7

    AST_LO_BLOCKS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !req_lvl |-> !busy_lo); // R7

    AST_GEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req && !gen |=> !irq_req); // R3

    AST_VEC_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_vec[2:0] == 3'd3 && irq_vec < 8'h30); // R5

    AST_GRANT_MARKS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && req_lvl |=> busy_hi); // R7

    AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ret && busy_hi && !irq_ack |=> !busy_hi && $stable(busy_lo)); // R8
endmodule

bind irqv_ctrl irqv_chk u_irqv_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_req(irq_req),
    .irq_vec(irq_vec),
    .irq_ack(irq_ack),
    .irq_ret(irq_ret),
    .gen    (st_q.gen),
    .req_lvl(st_q.lvl),
    .busy_hi(st_q.busy_hi),
    .busy_lo(st_q.busy_lo)
);

// File: tb/test_irqv_ctrl.sv
`timescale 1ns/1ps
module test_irqv_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext0_n = 1'b1, ext1_n = 1'b1;
    logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tmr2_evt = 1'b0, ser_evt = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_ack = 1'b0, irq_ret = 1'b0;
    int         n_run = 0, n_fail = 0;

    localparam logic [1:0] A_EN = 2'd0, A_PRI = 2'd1, A_FLG = 2'd2, A_MOD = 2'd3;

    always #10 clk = ~clk;

    irqv_ctrl i_irqv_ctrl (
        .clk(clk), .rst_n(rst_n), .ext0_n(ext0_n), .ext1_n(ext1_n),
        .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tmr2_evt(tmr2_evt), .ser_evt(ser_evt),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] v);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic ack1();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret1();
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    task automatic expect_req(string tag, logic [7:0] v);
        chk({tag, " req"}, {7'd0, irq_req}, 8'h01);
        chk({tag, " vec"}, irq_vec, v);
    endtask

    task automatic serve(string tag, logic [7:0] v);
        expect_req(tag, v);
        ack1();
        ret1();
        tick(1);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg after reset", v, 8'h00);
        end
        chk("R1 req after reset", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(A_PRI, 8'hFF); rd(A_PRI, v); chk("R2 priority readback", v, 8'h3F);
        wr(A_PRI, 8'h00);
        wr(A_MOD, 8'hFF); rd(A_MOD, v); chk("R2 mode readback", v, 8'h03);
        wr(A_FLG, 8'hFF); rd(A_FLG, v); chk("R2 flag readback", v, 8'h3F);
        wr(A_FLG, 8'h00);
        wr(A_EN, 8'hFF);  rd(A_EN, v);  chk("R2 enable readback", v, 8'hBF);
        tick(2);
        chk("R2 no flags no req", {7'd0, irq_req}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        wr(A_MOD, 8'h03);
        wr(A_EN, 8'h3F);
        wr(A_FLG, 8'h3F);
        tick(3);
        chk("R3 master off no req", {7'd0, irq_req}, 8'h00);
        wr(A_EN, 8'hBF);
        tick(1);
        serve("R5 ext0 first", 8'h03);
        serve("R5 tmr0 second", 8'h0B);
        serve("R5 ext1 third", 8'h13);
        serve("R5 tmr1 fourth", 8'h1B);
        serve("R5 serial fifth", 8'h23);
        rd(A_FLG, v); chk("R12 flags left", v, 8'h30);
        expect_req("R12 serial again", 8'h23);
        ack1();
        wr(A_FLG, 8'h20);
        ret1(); tick(1);
        expect_req("R5 tmr2 last", 8'h2B);
        ack1();
        rd(A_FLG, v); chk("R12 tmr2 flag kept", v, 8'h20);
        wr(A_FLG, 8'h00);
        ret1(); tick(1);
        chk("R5 all served", {7'd0, irq_req}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_mask();
        wr(A_EN, 8'hBC);
        wr(A_FLG, 8'h03);
        tick(2);
        chk("R4 disabled sources quiet", {7'd0, irq_req}, 8'h00);
        wr(A_FLG, 8'h07);
        tick(1);
        serve("R4 ext1 despite lower bits", 8'h13);
        wr(A_EN, 8'h00);
        wr(A_FLG, 8'h00);
    endtask

    task automatic t_nest();
        wr(A_PRI, 8'h20);
        wr(A_EN, 8'hBF);
        wr(A_FLG, 8'h21);
        tick(1);
        expect_req("R6 high beats ext0", 8'h2B);
        ack1();
        tick(2);
        chk("R7 high busy blocks", {7'd0, irq_req}, 8'h00);
        wr(A_FLG, 8'h01);
        ret1(); tick(1);
        expect_req("R7 low after high done", 8'h03);
        ack1();
        wr(A_FLG, 8'h20);
        tick(1);
        expect_req("R7 high preempts low", 8'h2B);
        ack1();
        ret1(); tick(1);
        expect_req("R8 ret frees high first", 8'h2B);
        ack1();
        wr(A_FLG, 8'h04);
        ret1(); tick(2);
        chk("R8 low still busy", {7'd0, irq_req}, 8'h00);
        ret1(); tick(1);
        serve("R8 low freed", 8'h13);
        chk("R8 idle", {7'd0, irq_req}, 8'h00);
        wr(A_PRI, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_hold();
        wr(A_EN, 8'hBF);
        wr(A_FLG, 8'h10);
        tick(1);
        expect_req("R9 serial raised", 8'h23);
        wr(A_FLG, 8'h11);
        tick(2);
        expect_req("R9 held over new flag", 8'h23);
        wr(A_EN, 8'h00);
        tick(1);
        expect_req("R9 held over disable", 8'h23);
        ack1(); ret1();
        wr(A_FLG, 8'h00);
        tick(1);
        chk("R9 released", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_ext();
        logic [7:0] v;
        wr(A_MOD, 8'h01);
        wr(A_EN, 8'h85);
        ext0_n = 1'b0;
        tick(2);
        rd(A_FLG, v); chk("R10 edge sets flag", v & 8'h05, 8'h01);
        tick(1);
        expect_req("R10 ext0 req", 8'h03);
        ack1();
        rd(A_FLG, v); chk("R10 ack clears edge flag", v & 8'h05, 8'h00);
        ret1(); tick(2);
        chk("R10 no retrigger while low", {7'd0, irq_req}, 8'h00);
        ext1_n = 1'b0;
        tick(2);
        rd(A_FLG, v); chk("R11 level sets flag", v & 8'h04, 8'h04);
        tick(1);
        expect_req("R11 ext1 req", 8'h13);
        ack1();
        rd(A_FLG, v); chk("R11 ack keeps level flag", v & 8'h04, 8'h04);
        ext1_n = 1'b1;
        tick(3);
        rd(A_FLG, v); chk("R11 flag follows pin", v & 8'h04, 8'h00);
        ret1(); tick(2);
        chk("R11 idle after release", {7'd0, irq_req}, 8'h00);
        ext0_n = 1'b1;
        wr(A_EN, 8'h00);
        wr(A_MOD, 8'h00);
        tick(3);
    endtask

    task automatic t_timers();
        logic [7:0] v;
        wr(A_EN, 8'h8A);
        tmr0_ovf = 1'b1; tmr1_ovf = 1'b1;
        @(negedge clk);
        tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
        tick(1);
        expect_req("R12 tmr0 wins", 8'h0B);
        ack1();
        rd(A_FLG, v); chk("R12 tmr0 cleared", v, 8'h08);
        ret1(); tick(1);
        expect_req("R12 tmr1 next", 8'h1B);
        ack1();
        rd(A_FLG, v); chk("R12 tmr1 cleared", v, 8'h00);
        ret1();
        wr(A_EN, 8'hA0);
        tmr2_evt = 1'b1;
        @(negedge clk);
        tmr2_evt = 1'b0;
        tick(1);
        expect_req("R12 tmr2 port", 8'h2B);
        ack1();
        rd(A_FLG, v); chk("R12 tmr2 kept", v, 8'h20);
        wr(A_FLG, 8'h00);
        ret1(); tick(1);
        chk("R12 idle", {7'd0, irq_req}, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    task automatic t_wr_wins();
        logic [7:0] v;
        wr(A_EN, 8'h82);
        wr(A_FLG, 8'h02);
        tick(1);
        expect_req("R13 tmr0 raised", 8'h0B);
        reg_addr = A_FLG; reg_wdata = 8'h02; reg_we = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; irq_ack = 1'b0;
        rd(A_FLG, v); chk("R13 write beats clear", v, 8'h02);
        ret1(); tick(1);
        serve("R13 raised again", 8'h0B);
        rd(A_FLG, v); chk("R13 later clear", v, 8'h00);
        wr(A_EN, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_poll();
        t_mask();
        t_nest();
        t_hold();
        t_ext();
        t_timers();
        t_wr_wins();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule